// File: doc/BRIEF.md
# Sync Edge Ratio Pulse Generator

This block runs in the converter clock domain. It watches an external sync input that has already been delayed, and it counts the rising edges it sees there. Once a programmed number of edges has arrived, it emits one initialization pulse that is a single clock wide. The pulse is meant to load a downstream clock-generation state machine, which has 32 states. When the sync input runs faster than the clock divided by 32, the surplus edges are dropped, so that pulses still land on multiples of 32 clocks.

A 3-bit ratio code selects how many edges are needed for each pulse. The count is always a power of two, from 1 to 16. The three codes above 4 are reserved. While one of them is applied, pulses are suppressed and a status flag is raised. Clearing the enable input, or changing the code, restarts the edge count.

Top module: `sync_ratio_pulse`

## Requirements
- R1: `init_pulse` is never high for two consecutive clocks.
- R2: Codes select the number of sync rising edges per pulse: 0 needs 1 edge, 1 needs 2, 2 needs 4, 3 needs 8, and 4 needs 16. Fewer edges than the selected count give no pulse.
- R3: While `ratio_sel` is 5, 6 or 7, `bad_ratio` reads 1 from the next clock onward, and `init_pulse` stays 0.
- R4: `bad_ratio` returns to 0 one clock after a valid code (0 to 4) is applied, and normal pulsing resumes.
- R5: Reset drives `init_pulse` and `bad_ratio` to 0 and clears the edge count, so counting restarts from zero after reset.
- R6: While `enable` is 0, no pulse is produced and the edge count is cleared.
- R7: A change of `ratio_sel` clears the edge count, so edges seen under the old code do not count toward the new one.
- R8: With code 0, the pulse is high in the third clock after the sync input is first sampled high, and low again in the fourth.
- R9: With the sync input at a quarter of the clock rate, code 3 spaces pulses 32 clocks apart and code 4 spaces them 64 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enables counting and pulse output |
| sync_in | input | 1 | Delayed external sync input, asynchronous |
| ratio_sel | input | 3 | Edge-ratio code; 0 to 4 are valid |
| init_pulse | output | 1 | Single-clock initialization pulse |
| bad_ratio | output | 1 | High while a reserved ratio code is applied |

## Verification
The hardest case to reach from the ports is a counter that holds a partial count at the moment its context changes. Three such changes matter: a new ratio code, a reset partway through a count, and a return from a reserved code. The stimulus builds a partial count on purpose in each case, for example three edges under code 2. It then switches context and sends exactly the number of edges that would complete a pulse only if the stale count had survived. The pulse spacing for quarter-rate sync is measured directly as the number of clocks between successive pulses.

// File: rtl/sync_ratio_pulse.sv
module sync_ratio_pulse #(
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_in,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             init_pulse,
  output logic             bad_ratio
);
  localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [2:0]       sync_sh;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             valid, sel_chg, rise, run, hit;

  assign valid   = ratio_sel <= SEL_W'(MAX_CODE);
  assign sel_chg = ratio_sel != sel_q;
  assign lim     = CNT_W'((32'd1 << ratio_sel) - 32'd1);
  assign rise    = sync_sh[1] & ~sync_sh[2];
  assign run     = enable & valid & ~sel_chg;
  assign hit     = rise && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_sh    <= '0;
      sel_q      <= '0;
      cnt        <= '0;
      init_pulse <= 1'b0;
      bad_ratio  <= 1'b0;
    end else begin
      sync_sh    <= {sync_sh[1:0], sync_in};
      sel_q      <= ratio_sel;
      bad_ratio  <= ~valid;
      init_pulse <= run & hit;
      if (!run)
        cnt <= '0;
      else if (rise)
        cnt <= hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

module sync_ratio_pulse_chk #(
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [SEL_W-1:0] ratio_sel,
  input logic             init_pulse,
  input logic             bad_ratio
);
  // R1
  single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);
  // R3
  bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel > SEL_W'(MAX_CODE)) |=> !init_pulse);
  // R3
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel > SEL_W'(MAX_CODE)) |=> bad_ratio);
  // R4
  good_code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel <= SEL_W'(MAX_CODE)) |=> !bad_ratio);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !init_pulse);
endmodule

bind sync_ratio_pulse sync_ratio_pulse_chk #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ratio_sel(ratio_sel),
  .init_pulse(init_pulse), .bad_ratio(bad_ratio));

// File: tb/test_sync_ratio_pulse.sv
module test_sync_ratio_pulse;
  localparam int CLK_P = 10;
  localparam int NV = 7;
  // {code, edges, period, expected pulses}
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 8'd3,  8'd32, 8'd3},
    {8'd1, 8'd5,  8'd8,  8'd2},
    {8'd2, 8'd9,  8'd8,  8'd2},
    {8'd3, 8'd17, 8'd4,  8'd2},
    {8'd4, 8'd33, 8'd4,  8'd2},
    {8'd3, 8'd7,  8'd6,  8'd0},
    {8'd4, 8'd15, 8'd4,  8'd0}};

  logic clk = 0, rst_n = 0, enable = 0, sync_in = 0;
  logic [2:0] ratio_sel = 3'd0;
  logic init_pulse, bad_ratio;
  int checks = 0, fails = 0, pcnt = 0, cyc = 0, t0 = 0, t1 = 0;

  sync_ratio_pulse i_sync_ratio_pulse (.clk(clk), .rst_n(rst_n), .enable(enable),
    .sync_in(sync_in), .ratio_sel(ratio_sel), .init_pulse(init_pulse), .bad_ratio(bad_ratio));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (init_pulse) begin
    if (pcnt == 0) t0 = cyc;
    if (pcnt == 1) t1 = cyc;
    pcnt = pcnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      repeat (per/2) @(negedge clk);
      sync_in = 1'b0;
      repeat (per - per/2) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic setup(input int code);
    enable = 1'b0; ratio_sel = 3'(code);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    pcnt = 0;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 pulse at reset", int'(init_pulse), 0);
    chk("R5 flag at reset", int'(bad_ratio), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      setup(int'(VEC[v][31:24]));
      edges(int'(VEC[v][23:16]), int'(VEC[v][15:8]));
      chk("R2 pulse count", pcnt, int'(VEC[v][7:0]));
    end

    // R8 latency and R1 width
    setup(0);
    sync_in = 1'b1;
    @(negedge clk); chk("R8 clock 1", int'(init_pulse), 0);
    @(negedge clk); chk("R8 clock 2", int'(init_pulse), 0);
    @(negedge clk); chk("R8 clock 3", int'(init_pulse), 1);
    @(negedge clk); chk("R1 clock 4", int'(init_pulse), 0);
    sync_in = 1'b0;
    repeat (4) @(negedge clk);

    // R9 spacing
    setup(3); edges(24, 4);
    chk("R9 code 3 spacing", t1 - t0, 32);
    setup(4); edges(40, 4);
    chk("R9 code 4 spacing", t1 - t0, 64);

    // R3 reserved codes
    for (int c = 5; c < 8; c++) begin
      setup(c);
      chk("R3 flag", int'(bad_ratio), 1);
      edges(8, 4);
      chk("R3 no pulse", pcnt, 0);
    end
    // R4 recovery
    ratio_sel = 3'd1;
    repeat (2) @(negedge clk);
    chk("R4 flag cleared", int'(bad_ratio), 0);
    pcnt = 0; edges(2, 4);
    chk("R4 pulsing resumes", pcnt, 1);

    // R6 disabled
    setup(0); enable = 1'b0;
    edges(4, 4);
    chk("R6 disabled no pulse", pcnt, 0);
    enable = 1'b1; repeat (2) @(negedge clk);

    // R7 code change clears count
    setup(2); edges(3, 4);
    chk("R7 partial count", pcnt, 0);
    ratio_sel = 3'd1; repeat (2) @(negedge clk);
    edges(1, 4);
    chk("R7 stale count dropped", pcnt, 0);
    edges(1, 4);
    chk("R7 fresh count pulse", pcnt, 1);

    // R5 reset mid-count
    setup(2); edges(2, 4);
    rst_n = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1; repeat (2) @(negedge clk);
    pcnt = 0; edges(2, 4);
    chk("R5 count cleared by reset", pcnt, 0);
    edges(2, 4);
    chk("R5 full count after reset", pcnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule